// File: doc/BRIEF.md
# Multi-Pointer Traceback Survivor Memory

This block holds the survivor decisions of an 8-state Viterbi decoder and turns them back into decoded bits by traceback. Each accepted trellis stage brings one decision column, with one bit per state. The columns go into a ring of equal banks. Several read pointers work on that ring at the same time. Each pointer starts at state zero on the newest column and walks backwards through a fixed depth so that the surviving paths merge. It then walks one further bank and emits one decoded bit per column.

Decoded bits leave newest first within each bank, and a marker flags the oldest bit of the bank. Putting the bits back into time order, computing branch metrics, running add-compare-select and choosing a best state are all done outside this block. The write pointer, the read pointers and the output move only on stages where the input is marked valid.

Top module: `trace_survivor_mem`

## Requirements
- R1: From reset, and after any later reset, all outputs are low. Accepted stages are counted from 0 after reset. The first decoded bit leaves one clock after accepted stage K*L-1+T, which is stage 19 with the defaults (V=3, K=3, T=8, bank length L=T/(K-1)=4, 2K=6 banks, 24 columns).
- R2: Bit s of a decision column is the decision of state s. From state s, one traceback or decode step moves to state {d, s[V-1:1]}, where d is that column's bit s. The decoded bit of a column is bit 0 of the state held when that column is read.
- R3: A new traceback job starts on every accepted stage that writes the last column of a bank, once K-1 banks have been filled before it. The job starts from state 0 on the column being written in that same cycle.
- R4: A job reads one column per accepted stage, moving backwards. The first T columns produce no output. The next L columns, which make up exactly one bank, each produce one decoded bit, newest column first.
- R5: bank_last_o is high only together with bit_valid_o, on the last of the L bits of each bank. It is high on every L-th decoded bit.
- R6: An idle stage (dec_valid_i low) writes nothing and moves no pointer. The next clock shows bit_valid_o low.
- R7: If the decision columns follow the true path of the input bits, each bank's output equals the input bits in reverse order. The write-to-decode distance is 2T to 2(T+L-1) accepted stages, and one register stage follows it.
- R8: The 2K*L-column ring is reused indefinitely. No column is overwritten before its last traceback or decode read.
- R9: At most one pointer decodes at any time. Once primed, every accepted stage yields exactly one decoded bit on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dec_valid_i | input | 1 | A decision column is present this cycle |
| dec_col_i | input | 2**V | Decision column; bit s belongs to state s |
| bit_valid_o | output | 1 | A decoded bit is present |
| bit_o | output | 1 | Decoded bit |
| bank_last_o | output | 1 | Marks the oldest (final) bit of a decoded bank |

## Verification
The bench targets four cases.

- **Priming edge.** A design that opens the first job one bank too early or too late puts out a bit at the wrong clock or misses it entirely.
- **Start column.** The start cycle must use the column that is being written in that same cycle. If the design reads memory there instead, it traces from a stale column, and with random decision columns the bits no longer agree with an independent traceback.
- **Stalls.** Random idle stages expose any pointer that keeps moving while the input is idle.
- **Long runs.** Runs that wrap the ring many times expose early overwrites and a misplaced bank-end marker.

A mid-run reset checks that priming starts again from nothing.

// File: rtl/tsm_pkg.sv
package tsm_pkg;
  // per-pointer decode output
  typedef struct packed {
    logic vld;
    logic bit_v;
    logic last;
  } dec_word_t;
endpackage

// File: rtl/tsm_wr_ctrl.sv
module tsm_wr_ctrl #(
  parameter int unsigned NB = 6,
  parameter int unsigned L  = 4,
  parameter int unsigned K  = 3,
  parameter int unsigned BW = 3,
  parameter int unsigned OW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  output logic [BW-1:0] wr_bank_o,
  output logic [OW-1:0] wr_off_o,
  output logic [K-1:0]  start_o
);
  localparam int unsigned FW = (K > 1) ? $clog2(K) : 1;
  localparam int unsigned SW = (K > 1) ? $clog2(K) : 1;

  logic [BW-1:0] bank_q;
  logic [OW-1:0] off_q;
  logic [FW-1:0] fill_q;
  logic [SW-1:0] slot_q;
  logic          bank_end, job_go;

  assign bank_end = valid_i && (off_q == OW'(L-1));
  assign job_go   = bank_end && (fill_q == FW'(K-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q <= '0;
      off_q  <= '0;
      fill_q <= '0;
      slot_q <= '0;
    end else begin
      if (valid_i) begin
        if (off_q == OW'(L-1)) begin
          off_q  <= '0;
          bank_q <= (bank_q == BW'(NB-1)) ? '0 : bank_q + BW'(1);
        end else begin
          off_q <= off_q + OW'(1);
        end
      end
      if (bank_end && fill_q != FW'(K-1)) fill_q <= fill_q + FW'(1);
      if (job_go) slot_q <= (slot_q == SW'(K-1)) ? '0 : slot_q + SW'(1);
    end
  end

  assign wr_bank_o = bank_q;
  assign wr_off_o  = off_q;

  for (genvar i = 0; i < K; i++) begin : g_start
    assign start_o[i] = job_go && (slot_q == SW'(i));
  end
endmodule

// File: rtl/tsm_bank_mem.sv
module tsm_bank_mem #(
  parameter int unsigned N  = 8,
  parameter int unsigned NB = 6,
  parameter int unsigned L  = 4,
  parameter int unsigned K  = 3,
  parameter int unsigned BW = 3,
  parameter int unsigned OW = 2
) (
  input  logic                   clk_i,
  input  logic                   we_i,
  input  logic [BW-1:0]          wbank_i,
  input  logic [OW-1:0]          woff_i,
  input  logic [N-1:0]           wdata_i,
  input  logic [K-1:0][BW-1:0]   rbank_i,
  input  logic [K-1:0][OW-1:0]   roff_i,
  output logic [K-1:0][N-1:0]    rdata_o
);
  logic [N-1:0] bank_word [K][NB];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [N-1:0] cols [L];
    always_ff @(posedge clk_i) begin
      if (we_i && wbank_i == BW'(b)) cols[woff_i] <= wdata_i;
    end
    for (genvar p = 0; p < K; p++) begin : g_rd
      assign bank_word[p][b] = cols[roff_i[p]];
    end
  end

  always_comb begin
    for (int p = 0; p < K; p++) rdata_o[p] = bank_word[p][rbank_i[p]];
  end
endmodule

// File: rtl/tsm_trace_unit.sv
module tsm_trace_unit
  import tsm_pkg::*;
#(
  parameter int unsigned V  = 3,
  parameter int unsigned NB = 6,
  parameter int unsigned L  = 4,
  parameter int unsigned T  = 8,
  parameter int unsigned BW = 3,
  parameter int unsigned OW = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic            start_i,
  input  logic [BW-1:0]   st_bank_i,
  input  logic [OW-1:0]   st_off_i,
  input  logic [(1<<V)-1:0] new_col_i,
  input  logic [(1<<V)-1:0] rd_col_i,
  output logic [BW-1:0]   rd_bank_o,
  output logic [OW-1:0]   rd_off_o,
  output logic            busy_o,
  output dec_word_t       dec_o
);
  localparam int unsigned N    = 1 << V;
  localparam int unsigned SPAN = T + L;
  localparam int unsigned CW   = $clog2(SPAN + 1);

  logic          busy_q;
  logic [CW-1:0] step_q, step_src;
  logic [BW-1:0] bank_q, cur_bank, nxt_bank;
  logic [OW-1:0] off_q, cur_off, nxt_off;
  logic [V-1:0]  st_q, st_src, pred;
  logic [N-1:0]  col_src;
  logic          run;

  always_comb begin
    // start cycle bypasses memory: column is being written right now
    col_src  = start_i ? new_col_i : rd_col_i;
    st_src   = start_i ? '0 : st_q;
    step_src = start_i ? '0 : step_q;
    cur_bank = start_i ? st_bank_i : bank_q;
    cur_off  = start_i ? st_off_i : off_q;
    run      = valid_i && (start_i || busy_q);
    pred     = {col_src[st_src], st_src[V-1:1]};
    if (cur_off == '0) begin
      nxt_off  = OW'(L-1);
      nxt_bank = (cur_bank == '0) ? BW'(NB-1) : cur_bank - BW'(1);
    end else begin
      nxt_off  = cur_off - OW'(1);
      nxt_bank = cur_bank;
    end
    dec_o.vld   = run && (step_src >= CW'(T));
    dec_o.bit_v = st_src[0];
    dec_o.last  = run && (step_src == CW'(SPAN-1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      step_q <= '0;
      bank_q <= '0;
      off_q  <= '0;
      st_q   <= '0;
    end else if (run) begin
      st_q   <= pred;
      step_q <= step_src + CW'(1);
      bank_q <= nxt_bank;
      off_q  <= nxt_off;
      busy_q <= (step_src != CW'(SPAN-1));
    end
  end

  assign rd_bank_o = bank_q;
  assign rd_off_o  = off_q;
  assign busy_o    = busy_q;
endmodule

// File: rtl/trace_survivor_mem.sv
module trace_survivor_mem
  import tsm_pkg::*;
#(
  parameter int unsigned V = 3,
  parameter int unsigned K = 3,
  parameter int unsigned T = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               dec_valid_i,
  input  logic [(1<<V)-1:0]  dec_col_i,
  output logic               bit_valid_o,
  output logic               bit_o,
  output logic               bank_last_o
);
  localparam int unsigned N            = 1 << V;
  localparam int unsigned L            = T / (K - 1);
  localparam int unsigned NB           = 2 * K;
  localparam int unsigned BW           = $clog2(NB);
  localparam int unsigned OW           = (L > 1) ? $clog2(L) : 1;
  localparam int unsigned PRIME_STAGES = K * L - 1 + T;

  logic [BW-1:0]        wr_bank;
  logic [OW-1:0]        wr_off;
  logic [K-1:0]         start_w, busy_w;
  logic [K-1:0][BW-1:0] rd_bank;
  logic [K-1:0][OW-1:0] rd_off;
  logic [K-1:0][N-1:0]  rd_col;
  dec_word_t [K-1:0]    dec_w;
  logic [K-1:0]         dec_vld_w, dec_bit_w, dec_last_w;

  tsm_wr_ctrl #(.NB(NB), .L(L), .K(K), .BW(BW), .OW(OW)) u_wr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (dec_valid_i),
    .wr_bank_o (wr_bank),
    .wr_off_o  (wr_off),
    .start_o   (start_w)
  );

  tsm_bank_mem #(.N(N), .NB(NB), .L(L), .K(K), .BW(BW), .OW(OW)) u_mem (
    .clk_i   (clk_i),
    .we_i    (dec_valid_i),
    .wbank_i (wr_bank),
    .woff_i  (wr_off),
    .wdata_i (dec_col_i),
    .rbank_i (rd_bank),
    .roff_i  (rd_off),
    .rdata_o (rd_col)
  );

  for (genvar i = 0; i < K; i++) begin : g_ptr
    tsm_trace_unit #(.V(V), .NB(NB), .L(L), .T(T), .BW(BW), .OW(OW)) u_ptr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .valid_i   (dec_valid_i),
      .start_i   (start_w[i]),
      .st_bank_i (wr_bank),
      .st_off_i  (wr_off),
      .new_col_i (dec_col_i),
      .rd_col_i  (rd_col[i]),
      .rd_bank_o (rd_bank[i]),
      .rd_off_o  (rd_off[i]),
      .busy_o    (busy_w[i]),
      .dec_o     (dec_w[i])
    );
    assign dec_vld_w[i]  = dec_w[i].vld;
    assign dec_bit_w[i]  = dec_w[i].bit_v;
    assign dec_last_w[i] = dec_w[i].last;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_valid_o <= 1'b0;
      bit_o       <= 1'b0;
      bank_last_o <= 1'b0;
    end else begin
      bit_valid_o <= |dec_vld_w;
      bit_o       <= |(dec_vld_w & dec_bit_w);
      bank_last_o <= |dec_last_w;
    end
  end
endmodule

// File: rtl/trace_survivor_mem_chk.sv
module trace_survivor_mem_chk #(
  parameter int unsigned K     = 3,
  parameter int unsigned L     = 4,
  parameter int unsigned PRIME = 19
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         dec_valid_i,
  input logic         bit_valid_o,
  input logic         bank_last_o,
  input logic [K-1:0] start_w,
  input logic [K-1:0] busy_w,
  input logic [K-1:0] dec_vld_w
);
  localparam int unsigned PW = $clog2(PRIME + 1);
  localparam int unsigned RW = $clog2(L + 1);

  logic [PW-1:0] stage_cnt;
  logic [RW-1:0] run_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_cnt <= '0;
      run_cnt   <= '0;
    end else begin
      if (dec_valid_i && stage_cnt != PW'(PRIME)) stage_cnt <= stage_cnt + PW'(1);
      if (bit_valid_o && bank_last_o) run_cnt <= '0;
      else if (bit_valid_o && run_cnt != RW'(L)) run_cnt <= run_cnt + RW'(1);
    end
  end

  assert_no_early_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_i && stage_cnt < PW'(PRIME)) |=> !bit_valid_o);

  assert_start_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_w & busy_w) == '0);

  assert_last_with_valid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_last_o |-> bit_valid_o);

  assert_last_spacing_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_last_o |-> run_cnt == RW'(L-1));

  assert_stall_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_valid_i |=> !bit_valid_o);

  assert_one_decoder_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dec_vld_w));

  assert_steady_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_i && stage_cnt == PW'(PRIME)) |=> bit_valid_o);
endmodule

bind trace_survivor_mem trace_survivor_mem_chk #(.K(K), .L(L), .PRIME(PRIME_STAGES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dec_valid_i (dec_valid_i),
  .bit_valid_o (bit_valid_o),
  .bank_last_o (bank_last_o),
  .start_w     (start_w),
  .busy_w      (busy_w),
  .dec_vld_w   (dec_vld_w)
);

// File: tb/trace_survivor_mem_tb_top.sv
module trace_survivor_mem_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TD    = 8;   // traceback depth
  localparam int BL    = 4;   // bank length
  localparam int NP    = 3;   // pointers
  localparam int PRIME = NP*BL - 1 + TD;

  typedef struct packed {
    logic b;
    logic last;
    logic ideal;
    int   t;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_ni;
  logic       dec_valid_i;
  logic [7:0] dec_col_i;
  logic       bit_valid_o, bit_o, bank_last_o;

  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  int   stage;
  logic [2:0] enc;
  byte  col_hist[$];
  bit   u_hist[$];
  bit   ideal_hist[$];
  exp_t exp_q[$];
  bit   exp_v;
  exp_t exp_cur;
  string exp_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  trace_survivor_mem dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .dec_valid_i (dec_valid_i),
    .dec_col_i   (dec_col_i),
    .bit_valid_o (bit_valid_o),
    .bit_o       (bit_o),
    .bank_last_o (bank_last_o)
  );

  task automatic clear_model();
    stage = 0; enc = '0; exp_v = 1'b0; exp_tag = "R1";
    col_hist.delete(); u_hist.delete(); ideal_hist.delete(); exp_q.delete();
  endtask

  task automatic check_outputs();
    checks++;
    if (bit_valid_o !== exp_v) begin
      errors++;
      $display("FAIL %s bit_valid_o act=%0b exp=%0b stage=%0d", exp_tag, bit_valid_o, exp_v, stage);
    end else if (exp_v) begin
      checks++;
      if (bit_o !== exp_cur.b) begin
        errors++;
        $display("FAIL R2 R3 R4 bit_o act=%0b exp=%0b col=%0d", bit_o, exp_cur.b, exp_cur.t);
      end
      checks++;
      if (bank_last_o !== exp_cur.last) begin
        errors++;
        $display("FAIL R5 bank_last_o act=%0b exp=%0b col=%0d", bank_last_o, exp_cur.last, exp_cur.t);
      end
      if (exp_cur.ideal) begin
        // R7 R8: ideal decisions reproduce the input bit of that column
        checks++;
        if (bit_o !== u_hist[exp_cur.t]) begin
          errors++;
          $display("FAIL R7 R8 bit_o act=%0b exp=%0b col=%0d", bit_o, u_hist[exp_cur.t], exp_cur.t);
        end
      end
    end else if (bank_last_o !== 1'b0) begin
      checks++;
      errors++;
      $display("FAIL R5 bank_last_o act=%0b exp=0 without a bit", bank_last_o);
    end
  endtask

  // one clock: check, drive, advance the model
  task automatic step(input bit v, input bit ideal);
    bit u;
    logic [7:0] col;
    @(negedge clk);
    check_outputs();
    u = 1'($urandom_range(1));
    col = ideal ? {8{enc[2]}} : 8'($urandom);
    dec_valid_i = v;
    dec_col_i = col;
    exp_v = 1'b0;
    exp_tag = v ? ((stage < PRIME) ? "R1" : "R9") : "R6";
    if (v) begin
      col_hist.push_back(col);
      u_hist.push_back(u);
      ideal_hist.push_back(ideal);
      if (ideal) enc = {enc[1:0], u};
      if ((stage % BL) == BL-1 && stage >= NP*BL-1) begin
        int st = 0;
        for (int j = 0; j < TD + BL; j++) begin
          int c = int'(col_hist[stage-j]);
          if (j >= TD) begin
            exp_t e;
            e.b = st[0]; e.last = (j == TD+BL-1); e.t = stage - j;
            e.ideal = ideal_hist[stage-j];
            exp_q.push_back(e);
          end
          st = (((c >> st) & 1) << 2) | (st >> 1);
        end
      end
      if (stage >= PRIME) begin
        exp_v = 1'b1;
        exp_cur = exp_q.pop_front();
      end
      stage++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    check_outputs();
    rst_ni = 1'b0;
    dec_valid_i = 1'b0;
    clear_model();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check_outputs(); // R1: outputs held low in reset
    end
    rst_ni = 1'b1;
  endtask

  initial begin
    rst_ni = 1'b0;
    dec_valid_i = 1'b0;
    dec_col_i = '0;
    clear_model();
    repeat (2) @(negedge clk);
    check_outputs(); // R1 reset state
    rst_ni = 1'b1;
    // ideal decisions, continuous, many ring wraps (R7, R8, R9)
    for (int i = 0; i < 400; i++) step(1'b1, 1'b1);
    // ideal decisions with idle stages (R6)
    for (int i = 0; i < 400; i++) step($urandom_range(3) != 0, 1'b1);
    // restart priming after a mid-run reset (R1)
    do_reset();
    // random decision columns exercise state selection (R2, R3, R4)
    for (int i = 0; i < 600; i++) step($urandom_range(4) != 0, 1'b0);
    for (int i = 0; i < 300; i++) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    @(negedge clk);
    check_outputs();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", checks, errors);
      $finish;
    end
  end
endmodule